// File: doc/BRIEF.md
# Banked In-Place Radix-4 FFT Core

This block computes a 64-point complex FFT in fixed point. Real and imaginary parts are 16-bit two's complement values. Samples enter on a ready/valid input stream. As each sample arrives it is written into four single-write, single-read RAM banks. The write position is the sample index with its base-4 digits reversed. Once the last sample is stored, the core runs three radix-4 passes in place. Each pass takes sixteen butterflies, and one butterfly is issued per clock. The finished spectrum then leaves on a ready/valid output stream in natural bin order, and the core returns to loading.

An element is placed in a bank chosen by the sum of its base-4 digits modulo 4, at a word address given by its upper digits. In every pass the four operands of a butterfly differ in exactly one digit. They therefore always sit in four different banks and can be read together in a single cycle. Operands 1 to 3 are rotated by Q1.15 twiddles derived from a quarter-wave cosine table. A 4-point DFT with only ±1/±j rotations follows, and the results are scaled down by four. After two cycles of pipeline they are written back to the word addresses they were read from. The full result is the DFT divided by 64.

Top module: `fft4_core`

## Requirements
- R1: After reset `in_ready` is 1 and `out_valid` is 0. Exactly 64 samples are accepted per frame, and `in_ready` is 0 in the cycle after the 64th accepted sample.
- R2: `in_ready` and `out_valid` are never high together. `out_valid` stays high for exactly 64 output transfers, after which the core is back in load with `in_ready` high.
- R3: Output transfer k (k = 0..63, in order) carries bin k of the DFT of the frame divided by 64. The DFT is X[k] = sum x[n]·exp(-j2πkn/64), and each component of the output is within ±4 LSB of the rounded value.
- R4: The four operands of every butterfly fall in four distinct banks. Results are written to the same bank addresses that were read, two cycles after the read, so arbitrary data transforms correctly.
- R5: Twiddles are Q1.15 cosine/sine values: 1.0 is stored as 32767, and W^e = cos(2πe/64) − j·sin(2πe/64). A complex tone at bin 5 comes out concentrated in bin 5.
- R6: Each pass computes (v + 2) >>> 2 on every butterfly output. An impulse of amplitude 6400 at n = 0 yields exactly 100 + j0 in every bin, and a constant 200 yields exactly 200 in bin 0 and 0 elsewhere.
- R7: While `out_valid` is high and `out_ready` is low, the output data holds steady. Cycles with `in_valid` low do not consume an input slot.
- R8: The first `out_valid` comes exactly 3·(16+2)+1 = 55 cycles after the cycle in which the 64th sample is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Core accepts a sample (load phase only) |
| in_re | input | DW | Input real part, signed |
| in_im | input | DW | Input imaginary part, signed |
| out_valid | output | 1 | Output bin valid (unload phase only) |
| out_ready | input | 1 | Downstream accepts the bin |
| out_re | output | DW | Output real part, signed |
| out_im | output | DW | Output imaginary part, signed |

## Verification
The bench builds the core with its defaults, DW = 16 and LOG4N = 3. This gives three passes, so pass 0 runs with unit twiddles and the later passes use exponents up to 45, reaching the first three quadrants of the cosine table. The 64-entry frame is small enough to compare every bin against a floating-point DFT. The bench drives impulses, a constant, a complex tone and random data, with input gaps and random output stalls.

// File: rtl/fft4_pkg.sv
package fft4_pkg;

  localparam int COEF_W = 16;  // Q1.15 twiddle width
  localparam int TW_LOG = 6;   // twiddle table covers 2^6 = 64 angles

  // quarter-wave cosine, cos(pi*r/32) in Q1.15, r = 0..16
  function automatic logic signed [COEF_W-1:0] quarter_cos(input logic [4:0] r);
    case (r)
      5'd0:    return 16'sd32767;
      5'd1:    return 16'sd32610;
      5'd2:    return 16'sd32138;
      5'd3:    return 16'sd31357;
      5'd4:    return 16'sd30274;
      5'd5:    return 16'sd28899;
      5'd6:    return 16'sd27246;
      5'd7:    return 16'sd25330;
      5'd8:    return 16'sd23170;
      5'd9:    return 16'sd20788;
      5'd10:   return 16'sd18205;
      5'd11:   return 16'sd15447;
      5'd12:   return 16'sd12540;
      5'd13:   return 16'sd9512;
      5'd14:   return 16'sd6393;
      5'd15:   return 16'sd3212;
      default: return 16'sd0;
    endcase
  endfunction

  // cos(2*pi*e/64) built from the quarter table by quadrant symmetry
  function automatic logic signed [COEF_W-1:0] tw_cos(input logic [TW_LOG-1:0] e);
    logic [4:0] r, rc;
    r  = {1'b0, e[3:0]};
    rc = 5'd16 - r;
    case (e[5:4])
      2'd0:    return quarter_cos(r);
      2'd1:    return -quarter_cos(rc);
      2'd2:    return -quarter_cos(r);
      default: return quarter_cos(rc);
    endcase
  endfunction

  // sin(2*pi*e/64)
  function automatic logic signed [COEF_W-1:0] tw_sin(input logic [TW_LOG-1:0] e);
    logic [4:0] r, rc;
    r  = {1'b0, e[3:0]};
    rc = 5'd16 - r;
    case (e[5:4])
      2'd0:    return quarter_cos(rc);
      2'd1:    return quarter_cos(r);
      2'd2:    return -quarter_cos(rc);
      default: return -quarter_cos(r);
    endcase
  endfunction

  // bank of an element: sum of its base-4 digits modulo 4
  function automatic logic [1:0] bank_of(input int unsigned idx, input int ndig);
    int unsigned s;
    s = 0;
    for (int d = 0; d < ndig; d++) s += (idx >> (2 * d)) & 32'd3;
    return 2'(s);
  endfunction

  // base-4 digit reversal over ndig digits
  function automatic int unsigned digit_rev(input int unsigned idx, input int ndig);
    int unsigned r;
    r = 0;
    for (int d = 0; d < ndig; d++) r = (r << 2) | ((idx >> (2 * d)) & 32'd3);
    return r;
  endfunction

endpackage

// File: rtl/fft4_agu.sv
// Operand indices and twiddle exponents of one butterfly in one pass.
module fft4_agu #(
  parameter int LOG4N = 3,
  parameter int AW    = 2 * LOG4N,
  parameter int PW    = $clog2(LOG4N + 1)
) (
  input  logic [PW-1:0]                   pass_i,
  input  logic [AW-3:0]                   bfly_i,
  output logic [3:0][AW-1:0]              idx_o,
  output logic [3:0][fft4_pkg::TW_LOG-1:0] exp_o
);
  import fft4_pkg::*;

  localparam int TW_SHIFT = TW_LOG - AW;  // N-scale exponent to 64-scale

  int sp_sh, span, j, g, base, tw_sh;

  always_comb begin
    sp_sh = 2 * int'(pass_i);
    span  = 1 << sp_sh;
    j     = int'(bfly_i) & (span - 1);
    g     = int'(bfly_i) >> sp_sh;
    base  = (g << (sp_sh + 2)) | j;
    tw_sh = 2 * (LOG4N - 1 - int'(pass_i)) + TW_SHIFT;
    for (int k = 0; k < 4; k++) begin
      idx_o[k] = AW'(base + k * span);
      exp_o[k] = TW_LOG'((k * j) << tw_sh);
    end
  end

endmodule

// File: rtl/fft4_bfly.sv
// Two-stage radix-4 datapath: twiddle rotation, then 4-point DFT with /4 scaling.
module fft4_bfly #(
  parameter int DW = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              vld_i,
  input  logic [3:0][DW-1:0]                op_re_i,
  input  logic [3:0][DW-1:0]                op_im_i,
  input  logic [3:0][fft4_pkg::TW_LOG-1:0]  exp_i,
  output logic                              vld_o,
  output logic [3:0][DW-1:0]                res_re_o,
  output logic [3:0][DW-1:0]                res_im_o
);
  import fft4_pkg::*;

  localparam int RW  = DW + 2;          // rotated operand width
  localparam int SW  = RW + 2;          // butterfly sum width
  localparam int PWD = DW + COEF_W + 1; // product sum width
  localparam logic signed [PWD-1:0] RND    = PWD'(1) <<< (COEF_W - 2);
  localparam logic signed [SW-1:0]  SAT_HI = SW'((1 << (DW - 1)) - 1);
  localparam logic signed [SW-1:0]  SAT_LO = SW'(-(1 << (DW - 1)));

  // real part of x * (c - j s)
  function automatic logic signed [RW-1:0] rot_re(input logic signed [DW-1:0] xr, xi,
                                                  input logic signed [COEF_W-1:0] c, s);
    logic signed [PWD-1:0] p;
    p = PWD'(xr) * PWD'(c) + PWD'(xi) * PWD'(s) + RND;
    return RW'(p >>> (COEF_W - 1));
  endfunction

  // imaginary part of x * (c - j s)
  function automatic logic signed [RW-1:0] rot_im(input logic signed [DW-1:0] xr, xi,
                                                  input logic signed [COEF_W-1:0] c, s);
    logic signed [PWD-1:0] p;
    p = PWD'(xi) * PWD'(c) - PWD'(xr) * PWD'(s) + RND;
    return RW'(p >>> (COEF_W - 1));
  endfunction

  // (v + 2) >>> 2 with saturation to DW bits
  function automatic logic [DW-1:0] scale_sat(input logic signed [SW-1:0] v);
    logic signed [SW-1:0] q;
    q = (v + SW'(2)) >>> 2;
    if (q > SAT_HI) return DW'(SAT_HI);
    if (q < SAT_LO) return DW'(SAT_LO);
    return DW'(q);
  endfunction

  logic signed [RW-1:0] t_re [4];
  logic signed [RW-1:0] t_im [4];
  logic                 t_vld;
  logic signed [SW-1:0] a_re [4];
  logic signed [SW-1:0] a_im [4];
  logic signed [SW-1:0] y_re [4];
  logic signed [SW-1:0] y_im [4];

  // stage 1: operand 0 passes, operands 1..3 are rotated
  always_ff @(posedge clk) begin
    if (!rst_n) t_vld <= 1'b0;
    else        t_vld <= vld_i;
    t_re[0] <= RW'($signed(op_re_i[0]));
    t_im[0] <= RW'($signed(op_im_i[0]));
    for (int k = 1; k < 4; k++) begin
      t_re[k] <= rot_re($signed(op_re_i[k]), $signed(op_im_i[k]),
                        tw_cos(exp_i[k]), tw_sin(exp_i[k]));
      t_im[k] <= rot_im($signed(op_re_i[k]), $signed(op_im_i[k]),
                        tw_cos(exp_i[k]), tw_sin(exp_i[k]));
    end
  end

  // stage 2: 4-point DFT, trivial rotations only
  always_comb begin
    for (int k = 0; k < 4; k++) begin
      a_re[k] = SW'(t_re[k]);
      a_im[k] = SW'(t_im[k]);
    end
    y_re[0] = a_re[0] + a_re[1] + a_re[2] + a_re[3];
    y_im[0] = a_im[0] + a_im[1] + a_im[2] + a_im[3];
    y_re[1] = a_re[0] + a_im[1] - a_re[2] - a_im[3];
    y_im[1] = a_im[0] - a_re[1] - a_im[2] + a_re[3];
    y_re[2] = a_re[0] - a_re[1] + a_re[2] - a_re[3];
    y_im[2] = a_im[0] - a_im[1] + a_im[2] - a_im[3];
    y_re[3] = a_re[0] - a_im[1] - a_re[2] + a_im[3];
    y_im[3] = a_im[0] + a_re[1] - a_im[2] - a_re[3];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) vld_o <= 1'b0;
    else        vld_o <= t_vld;
    for (int k = 0; k < 4; k++) begin
      res_re_o[k] <= scale_sat(y_re[k]);
      res_im_o[k] <= scale_sat(y_im[k]);
    end
  end

endmodule

// File: rtl/fft4_bank.sv
// One data bank: one synchronous write port, one asynchronous read port.
module fft4_bank #(
  parameter int WW    = 32,
  parameter int DEPTH = 16,
  parameter int ABW   = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           we,
  input  logic [ABW-1:0] waddr,
  input  logic [WW-1:0]  wdata,
  input  logic [ABW-1:0] raddr,
  output logic [WW-1:0]  rdata
);
  logic [WW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/fft4_core.sv
module fft4_core #(
  parameter int DW    = 16,
  parameter int LOG4N = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_re,
  input  logic [DW-1:0] in_im,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_re,
  output logic [DW-1:0] out_im
);
  import fft4_pkg::*;

  localparam int N     = 4 ** LOG4N;
  localparam int AW    = 2 * LOG4N;
  localparam int DEPTH = N / 4;
  localparam int BAW   = AW - 2;
  localparam int BCW   = BAW + 1;
  localparam int PW    = $clog2(LOG4N + 1);
  localparam int WW    = 2 * DW;

  typedef enum logic [1:0] {ST_LOAD, ST_COMP, ST_UNLOAD} phase_t;

  phase_t         state;
  logic [AW-1:0]  cnt;
  logic [PW-1:0]  pass;
  logic [BCW-1:0] bcnt;

  logic in_fire, out_fire, issue;
  assign in_ready  = (state == ST_LOAD);
  assign out_valid = (state == ST_UNLOAD);
  assign in_fire   = in_valid & in_ready;
  assign out_fire  = out_valid & out_ready;
  assign issue     = (state == ST_COMP) && (bcnt < BCW'(DEPTH));

  // operand addressing
  logic [3:0][AW-1:0]     idx;
  logic [3:0][TW_LOG-1:0] exps;
  logic [1:0]             rot;

  fft4_agu #(.LOG4N(LOG4N), .AW(AW), .PW(PW)) u_agu (
    .pass_i(pass), .bfly_i(bcnt[BAW-1:0]), .idx_o(idx), .exp_o(exps)
  );

  assign rot = bank_of(32'(idx[0]), LOG4N);

  // banks
  logic [3:0]          we;
  logic [3:0][BAW-1:0] waddr, raddr;
  logic [3:0][WW-1:0]  wdata, rdata;

  for (genvar b = 0; b < 4; b++) begin : g_bank
    fft4_bank #(.WW(WW), .DEPTH(DEPTH), .ABW(BAW)) u_bank (
      .clk(clk), .we(we[b]), .waddr(waddr[b]), .wdata(wdata[b]),
      .raddr(raddr[b]), .rdata(rdata[b])
    );
  end

  // read side: bank b serves operand (b - rot) during compute
  logic [1:0] ob;
  assign ob = bank_of(32'(cnt), LOG4N);

  always_comb begin
    for (int b = 0; b < 4; b++) begin
      if (state == ST_UNLOAD) raddr[b] = cnt[AW-1:2];
      else                    raddr[b] = idx[2'(2'(b) - rot)][AW-1:2];
    end
  end

  assign out_re = rdata[ob][WW-1:DW];
  assign out_im = rdata[ob][DW-1:0];

  logic [3:0][DW-1:0] op_re, op_im;
  always_comb begin
    for (int k = 0; k < 4; k++) begin
      op_re[k] = rdata[2'(2'(k) + rot)][WW-1:DW];
      op_im[k] = rdata[2'(2'(k) + rot)][DW-1:0];
    end
  end

  // datapath
  logic               bf_vld;
  logic [3:0][DW-1:0] res_re, res_im;

  fft4_bfly #(.DW(DW)) u_bfly (
    .clk(clk), .rst_n(rst_n), .vld_i(issue),
    .op_re_i(op_re), .op_im_i(op_im), .exp_i(exps),
    .vld_o(bf_vld), .res_re_o(res_re), .res_im_o(res_im)
  );

  // read-to-write delay registers covering the datapath latency
  logic [1:0]          s1_rot, s2_rot;
  logic [3:0][BAW-1:0] s1_addr, s2_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_rot <= '0; s2_rot <= '0; s1_addr <= '0; s2_addr <= '0;
    end else begin
      s1_rot <= rot;
      for (int k = 0; k < 4; k++) s1_addr[k] <= idx[k][AW-1:2];
      s2_rot  <= s1_rot;
      s2_addr <= s1_addr;
    end
  end

  // write side: load in digit-reversed order, or butterfly write-back
  logic [AW-1:0] ld_elem;
  logic [1:0]    ld_bank;
  assign ld_elem = AW'(digit_rev(32'(cnt), LOG4N));
  assign ld_bank = bank_of(32'(ld_elem), LOG4N);

  always_comb begin
    we = '0; waddr = '0; wdata = '0;
    if (in_fire) begin
      we[ld_bank]    = 1'b1;
      waddr[ld_bank] = ld_elem[AW-1:2];
      wdata[ld_bank] = {in_re, in_im};
    end else if (bf_vld) begin
      for (int k = 0; k < 4; k++) begin
        we[2'(2'(k) + s2_rot)]    = 1'b1;
        waddr[2'(2'(k) + s2_rot)] = s2_addr[k];
        wdata[2'(2'(k) + s2_rot)] = {res_re[k], res_im[k]};
      end
    end
  end

  // phase sequencing
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_LOAD; cnt <= '0; pass <= '0; bcnt <= '0;
    end else begin
      case (state)
        ST_LOAD: if (in_fire) begin
          cnt <= cnt + 1'b1;
          if (cnt == AW'(N - 1)) begin
            state <= ST_COMP; pass <= '0; bcnt <= '0;
          end
        end
        ST_COMP: begin
          if (bcnt == BCW'(DEPTH + 1)) begin
            bcnt <= '0;
            if (pass == PW'(LOG4N - 1)) begin
              state <= ST_UNLOAD; pass <= '0;
            end else begin
              pass <= pass + 1'b1;
            end
          end else begin
            bcnt <= bcnt + 1'b1;
          end
        end
        ST_UNLOAD: if (out_fire) begin
          cnt <= cnt + 1'b1;
          if (cnt == AW'(N - 1)) state <= ST_LOAD;
        end
        default: state <= ST_LOAD;
      endcase
    end
  end

  // assertions
  logic [3:0] bank_mask;
  always_comb begin
    bank_mask = '0;
    for (int k = 0; k < 4; k++) bank_mask[bank_of(32'(idx[k]), LOG4N)] = 1'b1;
  end

  AST_BANKS_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n) issue |-> $countones(bank_mask) == 4); // R4
  AST_WB_ALIGN: assert property (@(posedge clk) disable iff (!rst_n) issue |-> ##2 bf_vld); // R4
  AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(in_ready && out_valid)); // R2
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && !out_ready) |=> (out_valid && $stable(out_re) && $stable(out_im))); // R7
  AST_NO_WRITE_UNLOAD: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> (we == 4'b0000)); // R7

endmodule

// File: tb/fft4_core_test.sv
module fft4_core_test;
  localparam int DW    = 16;
  localparam int LOG4N = 3;
  localparam int N     = 64;
  localparam int LAT   = LOG4N * (N / 4 + 2) + 1;
  localparam real PI   = 3.14159265358979;

  logic clk = 1'b0;
  logic rst_n, in_valid, in_ready, out_valid, out_ready;
  logic [DW-1:0] in_re, in_im, out_re, out_im;

  always #5 clk = ~clk;

  fft4_core #(.DW(DW), .LOG4N(LOG4N)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_re(in_re), .in_im(in_im), .out_valid(out_valid), .out_ready(out_ready),
    .out_re(out_re), .out_im(out_im)
  );

  int checks = 0, fails = 0;
  bit mon_en = 0, bp_en = 0, done = 0;
  int xr [N];
  int xi [N];
  int q_re[$], q_im[$], q_tol[$];
  string q_tag[$];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // driver: predict the frame, queue it, then stream it in
  task automatic send_frame(input string tag, input int tol, input bit gaps);
    for (int k = 0; k < N; k++) begin
      real sr, si, a;
      sr = 0.0; si = 0.0;
      for (int n = 0; n < N; n++) begin
        a  = 2.0 * PI * real'(k * n) / real'(N);
        sr += real'(xr[n]) * $cos(a) + real'(xi[n]) * $sin(a);
        si += real'(xi[n]) * $cos(a) - real'(xr[n]) * $sin(a);
      end
      q_re.push_back(int'($floor(sr / real'(N) + 0.5)));
      q_im.push_back(int'($floor(si / real'(N) + 0.5)));
      q_tol.push_back(tol);
      q_tag.push_back(tag);
    end
    for (int n = 0; n < N; n++) begin
      @(posedge clk); #1;
      if (gaps) begin
        while ($urandom % 3 == 0) begin
          in_valid = 1'b0;
          @(posedge clk); #1;
        end
      end
      in_valid = 1'b1;
      in_re = DW'(xr[n]);
      in_im = DW'(xi[n]);
      forever begin
        @(negedge clk);
        if (in_ready) break;
      end
    end
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  // output backpressure
  initial begin
    out_ready = 1'b1;
    forever begin
      @(posedge clk); #1;
      out_ready = bp_en ? ($urandom % 3 != 0) : 1'b1;
    end
  end

  // monitor / scoreboard
  initial begin
    int acc_cnt = 0, out_cnt = 0, lat_cnt = 0;
    bit lat_armed = 0, chk_rdy_low = 0, chk_back = 0, hold_pend = 0;
    logic [DW-1:0] h_re = '0, h_im = '0;
    forever begin
      @(negedge clk);
      if (!mon_en) continue;
      check(!(in_ready && out_valid), "R2", "ready/valid overlap", int'(in_ready && out_valid), 0);
      if (hold_pend) begin
        check(out_valid && out_re == h_re && out_im == h_im, "R7", "held output re",
              int'($signed(out_re)), int'($signed(h_re)));
        hold_pend = 0;
      end
      if (chk_rdy_low) begin
        check(in_ready == 1'b0, "R1", "in_ready after 64th sample", int'(in_ready), 0);
        chk_rdy_low = 0;
      end
      if (chk_back) begin
        check(in_ready && !out_valid, "R2", "back to load after 64 outputs", int'(in_ready), 1);
        chk_back = 0;
      end
      if (lat_armed) begin
        lat_cnt++;
        if (out_valid) begin
          check(lat_cnt == LAT, "R8", "cycles to first output", lat_cnt, LAT);
          lat_armed = 0;
        end
      end
      if (in_valid && in_ready) begin
        acc_cnt++;
        if (acc_cnt == N) begin
          acc_cnt = 0; lat_armed = 1; lat_cnt = 0; chk_rdy_low = 1;
        end
      end
      if (out_valid && out_ready) begin
        if (q_re.size() == 0) begin
          check(0, "R2", "output with empty scoreboard", 1, 0);
        end else begin
          int er, ei, tl, ar, ai;
          string tg;
          er = q_re.pop_front(); ei = q_im.pop_front();
          tl = q_tol.pop_front(); tg = q_tag.pop_front();
          ar = int'($signed(out_re)); ai = int'($signed(out_im));
          check((ar - er <= tl) && (er - ar <= tl), tg, $sformatf("bin %0d re", out_cnt), ar, er);
          check((ai - ei <= tl) && (ei - ai <= tl), tg, $sformatf("bin %0d im", out_cnt), ai, ei);
        end
        out_cnt++;
        if (out_cnt == N) begin
          out_cnt = 0; chk_back = 1;
        end
      end else if (out_valid) begin
        hold_pend = 1; h_re = out_re; h_im = out_im;
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      summary();
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_re = '0; in_im = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1, "R1", "reset in_ready", int'(in_ready), 1);
    check(out_valid == 1'b0, "R1", "reset out_valid", int'(out_valid), 0);
    mon_en = 1;

    // R6: impulse at n=0 gives exactly 100 in every bin
    for (int n = 0; n < N; n++) begin xr[n] = 0; xi[n] = 0; end
    xr[0] = 6400;
    send_frame("R6", 0, 0);

    // R6: constant input, exact scaling, with input gaps (R7)
    for (int n = 0; n < N; n++) begin xr[n] = 200; xi[n] = 0; end
    send_frame("R6 R7", 0, 1);

    // R5: complex tone at bin 5 with output stalls
    bp_en = 1;
    for (int n = 0; n < N; n++) begin
      xr[n] = int'($floor(8000.0 * $cos(2.0 * PI * real'(5 * n) / real'(N)) + 0.5));
      xi[n] = int'($floor(8000.0 * $sin(2.0 * PI * real'(5 * n) / real'(N)) + 0.5));
    end
    send_frame("R5 R3", 4, 0);

    // R3: delayed impulse, rotating phase across bins
    for (int n = 0; n < N; n++) begin xr[n] = 0; xi[n] = 0; end
    xr[1] = 6400;
    send_frame("R3 R5", 4, 1);

    // R4: random data exercising every bank/address pattern
    for (int f = 0; f < 2; f++) begin
      for (int n = 0; n < N; n++) begin
        xr[n] = int'($urandom_range(16000, 0)) - 8000;
        xi[n] = int'($urandom_range(16000, 0)) - 8000;
      end
      send_frame("R3 R4", 4, f == 1);
    end

    while (q_re.size() > 0) @(posedge clk);
    repeat (5) @(posedge clk);
    done = 1;
    summary();
  end

endmodule